// File: doc/BRIEF.md
# Two-Level Interrupt Exception Entry Controller

This block holds the current status word of a processor core and carries out the status and control-flow steps of taking an interrupt. Two interrupt classes arrive as level-sensitive request pins: a normal interrupt and a fast interrupt. Each request is gated by its own mask bit in the status word. When a request is accepted, the block does four things on the same clock edge. It copies the status word into that class's saved status register and the incoming program counter into that class's link register. It sets the mask bits, writes the handler mode, and issues a one-cycle program counter load to the class's vector.

The fast class outranks the normal class. Fast entry masks both classes, while normal entry masks only itself, so a fast request can preempt a running normal handler. A single-cycle return strobe copies the current mode's saved status back into the status word and loads the program counter from that mode's link register. Privileged software can rewrite the control byte of the status word. A write made in user mode has no effect.

The status word layout:
- bits [4:0] hold the mode: user 0x10, fast handler 0x11, normal handler 0x12, kernel 0x13.
- bit 7 is the normal mask.
- bit 6 is the fast mask.
- All other bits stay zero unless a restore brings them back.

The instruction fetcher consumes the program counter load as a plain control pulse. No pin here takes back-pressure.

Top module: `ent_ctrl`

## Requirements
- R1: After reset the status word is 0xD3 (kernel mode 0x13, both masks set). Both saved status registers and both link registers read zero, and `pc_load_o` is 0.
- R2: A request is taken only while its mask bit is 0 (bit 7 for normal, bit 6 for fast). A masked request leaves the status word, the saved and link registers, and `pc_load_o` unchanged.
- R3: On normal entry, the following all appear one cycle after the edge on which the request was accepted:
  - the old status word is in the normal saved register, and `pc_i` is in the normal link register;
  - the mode is 0x12, bit 7 is set, and bit 6 keeps its value;
  - `pc_load_o` pulses with target 0x18.
- R4: On fast entry, the old status word goes to the fast saved register and `pc_i` to the fast link register. The mode becomes 0x11, bits 7 and 6 are both set, and `pc_load_o` pulses with target 0x1C.
- R5: When both requests are unmasked in the same cycle, the fast request is taken and the normal registers are untouched.
- R6: A fast request raised during a normal handler is taken. The fast saved register then holds the normal-handler status word (0x92 when entered from 0x13). The normal saved and link registers keep their contents.
- R7: A return strobe in mode 0x11 or 0x12 does two things. It copies that mode's saved status into the status word, and it pulses `pc_load_o` with that mode's link register as the target. In any other mode the strobe has no effect.
- R8: A return strobe that is honoured takes precedence over an entry in the same cycle. The still-pending request is then judged on the next cycle against the restored masks.
- R9: `ctl_wr_i` replaces bits [7:0] of the status word with `ctl_wdata_i` when the mode is not user (0x10) and no entry or return happens in that cycle. In user mode the write is ignored.
- R10: `pc_load_o` is high for exactly one cycle per entry or return and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nrm_req_i | input | 1 | Normal interrupt request, level |
| fst_req_i | input | 1 | Fast interrupt request, level |
| pc_i | input | PC_W | Return address captured on entry |
| ret_i | input | 1 | Single-cycle return strobe |
| ctl_wr_i | input | 1 | Software write of the status control byte |
| ctl_wdata_i | input | 8 | Data for the control byte write |
| status_o | output | SR_W | Current status word |
| pc_load_o | output | 1 | One-cycle program counter load |
| pc_target_o | output | PC_W | Program counter load value |
| nrm_saved_o | output | SR_W | Normal-handler saved status |
| nrm_link_o | output | PC_W | Normal-handler link register |
| fst_saved_o | output | SR_W | Fast-handler saved status |
| fst_link_o | output | PC_W | Fast-handler link register |

## Verification
The hardest situation to reach from the ports is a return strobe and a newly unmasked fast request landing in the same cycle inside a normal handler. Reaching it takes three steps:
1. The bench first clears the masks with a kernel-mode control write.
2. It then takes a normal entry.
3. Finally it raises the return strobe and the fast request on the same falling edge.

It then checks that the restore happens first and the fast entry follows one cycle later, saving the restored kernel status. User mode is reachable only through a privileged control write. The bench uses that path to show that user-mode writes and returns are ignored.

// File: rtl/ent_pkg.sv
package ent_pkg;
  localparam int MODE_W  = 5;
  localparam int NM_BIT  = 7;
  localparam int FM_BIT  = 6;
  localparam int N_BANK  = 2;
  localparam int BANK_NRM = 0;
  localparam int BANK_FST = 1;

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FST = 5'h11;
  localparam logic [MODE_W-1:0] MODE_NRM = 5'h12;
  localparam logic [MODE_W-1:0] MODE_KRN = 5'h13;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_NRM,
    ACT_FST,
    ACT_RET,
    ACT_CTL
  } act_e;
endpackage

// File: rtl/ent_arb.sv
module ent_arb
  import ent_pkg::*;
(
  input  logic              nrm_req_i,
  input  logic              fst_req_i,
  input  logic              ret_i,
  input  logic              ctl_wr_i,
  input  logic              nrm_msk_i,
  input  logic              fst_msk_i,
  input  logic [MODE_W-1:0] mode_i,
  output act_e              act_o
);
  logic ret_ok, fst_ok, nrm_ok, priv;

  assign ret_ok = ret_i && (mode_i == MODE_FST || mode_i == MODE_NRM);
  assign fst_ok = fst_req_i && !fst_msk_i;
  assign nrm_ok = nrm_req_i && !nrm_msk_i;
  assign priv   = (mode_i != MODE_USR);

  always_comb begin
    if (ret_ok)                act_o = ACT_RET;
    else if (fst_ok)           act_o = ACT_FST;
    else if (nrm_ok)           act_o = ACT_NRM;
    else if (ctl_wr_i && priv) act_o = ACT_CTL;
    else                       act_o = ACT_IDLE;
  end
endmodule

// File: rtl/ent_bank.sv
module ent_bank #(
  parameter int SR_W = 32,
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,
  input  logic [SR_W-1:0] sr_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [SR_W-1:0] saved_o,
  output logic [PC_W-1:0] link_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saved_o <= '0;
      link_o  <= '0;
    end else if (cap_i) begin
      saved_o <= sr_i;
      link_o  <= pc_i;
    end
  end

  AST_BANK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (saved_o == $past(sr_i)) && (link_o == $past(pc_i))); // R3
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(saved_o) && $stable(link_o)); // R6
endmodule

// File: rtl/ent_ctrl.sv
module ent_ctrl
  import ent_pkg::*;
#(
  parameter int SR_W    = 32,
  parameter int PC_W    = 32,
  parameter int NRM_VEC = 32'h18,
  parameter int FST_VEC = 32'h1C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nrm_req_i,
  input  logic            fst_req_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            ret_i,
  input  logic            ctl_wr_i,
  input  logic [7:0]      ctl_wdata_i,
  output logic [SR_W-1:0] status_o,
  output logic            pc_load_o,
  output logic [PC_W-1:0] pc_target_o,
  output logic [SR_W-1:0] nrm_saved_o,
  output logic [PC_W-1:0] nrm_link_o,
  output logic [SR_W-1:0] fst_saved_o,
  output logic [PC_W-1:0] fst_link_o
);
  localparam logic [SR_W-1:0] SR_RST =
    SR_W'((1 << NM_BIT) | (1 << FM_BIT)) | SR_W'(MODE_KRN);
  localparam logic [PC_W-1:0] NRM_PC = PC_W'(NRM_VEC);
  localparam logic [PC_W-1:0] FST_PC = PC_W'(FST_VEC);

  logic [SR_W-1:0]   sr_q, sr_d;
  logic              pcl_q, pcl_d;
  logic [PC_W-1:0]   pct_q, pct_d;
  logic [MODE_W-1:0] mode_w;
  act_e              act;
  logic [N_BANK-1:0] cap;
  logic [SR_W-1:0]   saved_w [N_BANK];
  logic [PC_W-1:0]   link_w  [N_BANK];
  logic              rb;

  assign mode_w = sr_q[MODE_W-1:0];

  ent_arb u_arb (
    .nrm_req_i (nrm_req_i),
    .fst_req_i (fst_req_i),
    .ret_i     (ret_i),
    .ctl_wr_i  (ctl_wr_i),
    .nrm_msk_i (sr_q[NM_BIT]),
    .fst_msk_i (sr_q[FM_BIT]),
    .mode_i    (mode_w),
    .act_o     (act)
  );

  assign cap[BANK_NRM] = (act == ACT_NRM);
  assign cap[BANK_FST] = (act == ACT_FST);

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    ent_bank #(.SR_W(SR_W), .PC_W(PC_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap[g]),
      .sr_i    (sr_q),
      .pc_i    (pc_i),
      .saved_o (saved_w[g]),
      .link_o  (link_w[g])
    );
  end

  assign rb = (mode_w == MODE_FST);

  always_comb begin
    sr_d  = sr_q;
    pcl_d = 1'b0;
    pct_d = pct_q;
    case (act)
      ACT_NRM: begin
        sr_d[NM_BIT]       = 1'b1;
        sr_d[MODE_W-1:0]   = MODE_NRM;
        pcl_d              = 1'b1;
        pct_d              = NRM_PC;
      end
      ACT_FST: begin
        sr_d[NM_BIT]       = 1'b1;
        sr_d[FM_BIT]       = 1'b1;
        sr_d[MODE_W-1:0]   = MODE_FST;
        pcl_d              = 1'b1;
        pct_d              = FST_PC;
      end
      ACT_RET: begin
        sr_d  = saved_w[rb];
        pcl_d = 1'b1;
        pct_d = link_w[rb];
      end
      ACT_CTL: sr_d[7:0] = ctl_wdata_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= SR_RST;
      pcl_q <= 1'b0;
      pct_q <= '0;
    end else begin
      sr_q  <= sr_d;
      pcl_q <= pcl_d;
      pct_q <= pct_d;
    end
  end

  assign status_o    = sr_q;
  assign pc_load_o   = pcl_q;
  assign pc_target_o = pct_q;
  assign nrm_saved_o = saved_w[BANK_NRM];
  assign nrm_link_o  = link_w[BANK_NRM];
  assign fst_saved_o = saved_w[BANK_FST];
  assign fst_link_o  = link_w[BANK_FST];

  logic ret_take, fst_acc, nrm_acc;
  assign ret_take = ret_i && (mode_w == MODE_FST || mode_w == MODE_NRM);
  assign fst_acc  = fst_req_i && !sr_q[FM_BIT];
  assign nrm_acc  = nrm_req_i && !sr_q[NM_BIT];

  AST_FST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (fst_acc && !ret_take) |=> (status_o[MODE_W-1:0] == MODE_FST) &&
      status_o[NM_BIT] && status_o[FM_BIT] && pc_load_o && (pc_target_o == FST_PC)); // R4
  AST_NRM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm_acc && !fst_acc && !ret_take) |=> (status_o[MODE_W-1:0] == MODE_NRM) &&
      status_o[NM_BIT] && (status_o[FM_BIT] == $past(sr_q[FM_BIT])) &&
      pc_load_o && (pc_target_o == NRM_PC)); // R3
  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_take && !fst_acc && !nrm_acc && !(ctl_wr_i && mode_w != MODE_USR))
      |=> $stable(status_o) && !pc_load_o); // R2
  AST_USER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MODE_USR && !fst_acc && !nrm_acc) |=> $stable(status_o)); // R9
  AST_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ret_take |=> pc_load_o &&
      (status_o == $past(mode_w == MODE_FST ? fst_saved_o : nrm_saved_o)) &&
      (pc_target_o == $past(mode_w == MODE_FST ? fst_link_o : nrm_link_o))); // R7
endmodule

// File: tb/tb_ent_ctrl.sv
`timescale 1ns/1ps
module tb_ent_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nrm_req = 1'b0, fst_req = 1'b0, ret = 1'b0, ctl_wr = 1'b0;
  logic [31:0] pc = '0;
  logic [7:0]  ctl_wdata = '0;
  logic [31:0] status, pc_target, nrm_saved, nrm_link, fst_saved, fst_link;
  logic        pc_load;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ent_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nrm_req_i(nrm_req), .fst_req_i(fst_req),
    .pc_i(pc), .ret_i(ret), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .status_o(status), .pc_load_o(pc_load), .pc_target_o(pc_target),
    .nrm_saved_o(nrm_saved), .nrm_link_o(nrm_link),
    .fst_saved_o(fst_saved), .fst_link_o(fst_link)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    step();
    ctl_wr = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1;
    step();
    ret = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 status", status, 32'hD3);
    chk("R1 nrm_saved", nrm_saved, 0);
    chk("R1 nrm_link", nrm_link, 0);
    chk("R1 fst_saved", fst_saved, 0);
    chk("R1 fst_link", fst_link, 0);
    chk("R1 pc_load", pc_load, 0);
  endtask

  task automatic t_masked();
    nrm_req = 1'b1; fst_req = 1'b1; pc = 32'h500;
    step();
    chk("R2 masked status", status, 32'hD3);
    chk("R2 masked pc_load", pc_load, 0);
    step();
    chk("R2 masked nrm_link", nrm_link, 0);
    chk("R2 masked fst_link", fst_link, 0);
    nrm_req = 1'b0; fst_req = 1'b0;
  endtask

  task automatic t_ctl_write();
    ctl_write(8'h13);
    chk("R9 kernel write", status, 32'h13);
    chk("R10 no load on write", pc_load, 0);
  endtask

  task automatic t_nrm_entry();
    pc = 32'h1000; nrm_req = 1'b1;
    step();
    nrm_req = 1'b0;
    chk("R3 status", status, 32'h92);
    chk("R3 nrm_saved", nrm_saved, 32'h13);
    chk("R3 nrm_link", nrm_link, 32'h1000);
    chk("R3 pc_load", pc_load, 1);
    chk("R3 target", pc_target, 32'h18);
    chk("R3 fst_saved untouched", fst_saved, 0);
    step();
    chk("R10 single pulse", pc_load, 0);
  endtask

  task automatic t_fst_preempt();
    pc = 32'h2000; fst_req = 1'b1;
    step();
    fst_req = 1'b0;
    chk("R6 status", status, 32'hD1);
    chk("R6 fst_saved", fst_saved, 32'h92);
    chk("R4 fst_link", fst_link, 32'h2000);
    chk("R4 target", pc_target, 32'h1C);
    chk("R4 pc_load", pc_load, 1);
    chk("R6 nrm_saved kept", nrm_saved, 32'h13);
    chk("R6 nrm_link kept", nrm_link, 32'h1000);
    nrm_req = 1'b1;
    step();
    nrm_req = 1'b0;
    chk("R2 nrm masked in fast", status, 32'hD1);
    chk("R2 no load", pc_load, 0);
  endtask

  task automatic t_returns();
    do_ret();
    chk("R7 ret fast status", status, 32'h92);
    chk("R7 ret fast target", pc_target, 32'h2000);
    chk("R7 ret fast load", pc_load, 1);
    do_ret();
    chk("R7 ret nrm status", status, 32'h13);
    chk("R7 ret nrm target", pc_target, 32'h1000);
    do_ret();
    chk("R7 ret in kernel status", status, 32'h13);
    chk("R7 ret in kernel load", pc_load, 0);
  endtask

  task automatic t_both();
    pc = 32'h3000; nrm_req = 1'b1; fst_req = 1'b1;
    step();
    nrm_req = 1'b0; fst_req = 1'b0;
    chk("R5 status", status, 32'hD1);
    chk("R5 fst_saved", fst_saved, 32'h13);
    chk("R5 fst_link", fst_link, 32'h3000);
    chk("R5 target", pc_target, 32'h1C);
    chk("R5 nrm_link untouched", nrm_link, 32'h1000);
    do_ret();
    chk("R7 back to kernel", status, 32'h13);
  endtask

  task automatic t_ret_vs_entry();
    pc = 32'h4000; nrm_req = 1'b1;
    step();
    nrm_req = 1'b0;
    chk("R3 second entry", status, 32'h92);
    pc = 32'h4100; ret = 1'b1; fst_req = 1'b1;
    step();
    ret = 1'b0;
    chk("R8 return first status", status, 32'h13);
    chk("R8 return first target", pc_target, 32'h4000);
    step();
    fst_req = 1'b0;
    chk("R8 fast next status", status, 32'hD1);
    chk("R8 fast next saved", fst_saved, 32'h13);
    chk("R8 fast next link", fst_link, 32'h4100);
    chk("R8 fast next target", pc_target, 32'h1C);
    do_ret();
    chk("R7 restore kernel", status, 32'h13);
  endtask

  task automatic t_user();
    ctl_write(8'h10);
    chk("R9 enter user", status, 32'h10);
    ctl_write(8'hD3);
    chk("R9 user write ignored", status, 32'h10);
    do_ret();
    chk("R7 ret in user status", status, 32'h10);
    chk("R7 ret in user load", pc_load, 0);
    pc = 32'h5000; nrm_req = 1'b1;
    step();
    nrm_req = 1'b0;
    chk("R3 from user status", status, 32'h92);
    chk("R3 from user saved", nrm_saved, 32'h10);
    do_ret();
    chk("R7 back to user", status, 32'h10);
    chk("R7 user target", pc_target, 32'h5000);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_masked();
    t_ctl_write();
    t_nrm_entry();
    t_fst_preempt();
    t_returns();
    t_both();
    t_ret_vs_entry();
    t_user();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule